// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a parameterised set of external interrupt lines and presents them to a processor as one combined interrupt request. Software reaches it over a plain 32-bit register bus. Each line occupies one bit of a 32-bit word. Line `n` sits at bit `n % 32` of word `n / 32`, and the words of a group are 4 bytes apart.

Every line has five pieces of state: a trigger type (edge or level), an active sense (polarity), a mask, a software-forced request and a routing enable. Mask, trigger type, soft request and polarity each have three registers: a read-only readback word, a write-one-to-set alias and a write-one-to-clear alias. Routing enable is a plain read/write word.

Each input first passes through a two-flop synchroniser. Edge-type lines then latch a qualified edge until software acknowledges it. Level-type lines report their state live. Firmware can emulate triggering on both edges by flipping the polarity after each event and using the soft request to cover an edge that lands during the flip.

Top module: `xint_regbank`

## Requirements
- R1: After reset, every mask, trigger-type, soft, polarity and routing-enable bit reads 0, every status bit reads 0, and `irq_o` is low.
- R2: The group addresses are as follows.
  - Mask: readback 0x080, set 0x0C0, clear 0x100.
  - Trigger type: readback 0x140, set 0x180, clear 0x1C0.
  - Soft: readback 0x200, set 0x240, clear 0x280.
  - Polarity: readback 0x300, set 0x340, clear 0x380.
  A 1 written to a set alias sets that line's bit, and a 1 written to a clear alias clears it. A written 0 leaves the bit unchanged. The new value is visible on the next read.
- R3: Routing enable is read/write at 0x400 + 4·word. The status of a line whose routing bit is 0 reads 0, and such a line never drives `irq_o`.
- R4: With trigger type 1 (level), the status bit follows the synchronised input. It reads 1 while the input is high if polarity is 1, and while the input is low if polarity is 0.
- R5: With trigger type 0 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) sets a latched request. The latched request holds after the input returns. Writing 1 to that bit of the acknowledge word at 0x040 clears it, and 0 bits of the acknowledge word leave other lines latched.
- R6: Changing the polarity of an edge-type line while its input is steady latches no request.
- R7: A soft bit set to 1 makes the line's status read 1, provided routing is enabled.
- R8: `irq_o` is high exactly when some line has status 1 and mask 0. The mask bit value 1 means masked.
- R9: The status word at 0x000 is read-only, and so are the readback words at 0x080, 0x140, 0x200 and 0x300, so writes to them are ignored. Bits for line numbers at or above `NUM_LINES`, words beyond the last one, and the write-only alias and acknowledge words all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_line_i | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_addr_i | input | 10 | Byte address bits 11..2 |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the clock edge that samples it, and read data appears on `bus_rdata_o` at the edge that samples the read strobe. `irq_o` follows the stored state with no further delay, so both bus and interrupt results are compared on the falling edge after the access's rising edge. A level status follows an input change after two rising edges, and an edge request is latched after three. The bench therefore waits four full cycles after each input change before it reads, which keeps every comparison clear of the synchroniser latency.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int WORD_BITS = 32;
    localparam int WIDX_W    = 4;
    localparam int N_ATTR    = 4;

    localparam int IDX_MASK = 0;
    localparam int IDX_SENS = 1;
    localparam int IDX_SOFT = 2;
    localparam int IDX_POL  = 3;

    typedef enum logic [4:0] {
        GRP_STAT     = 5'd0,
        GRP_ACK      = 5'd1,
        GRP_MASK     = 5'd2,
        GRP_MASK_SET = 5'd3,
        GRP_MASK_CLR = 5'd4,
        GRP_SENS     = 5'd5,
        GRP_SENS_SET = 5'd6,
        GRP_SENS_CLR = 5'd7,
        GRP_SOFT     = 5'd8,
        GRP_SOFT_SET = 5'd9,
        GRP_SOFT_CLR = 5'd10,
        GRP_POL      = 5'd12,
        GRP_POL_SET  = 5'd13,
        GRP_POL_CLR  = 5'd14,
        GRP_DOM      = 5'd16
    } grp_e;

    typedef struct packed {
        logic              ack;
        logic              dom;
        logic [N_ATTR-1:0] set;
        logic [N_ATTR-1:0] clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(grp_e g);
        wr_dec_t d;
        d = '0;
        case (g)
            GRP_ACK:      d.ack           = 1'b1;
            GRP_DOM:      d.dom           = 1'b1;
            GRP_MASK_SET: d.set[IDX_MASK] = 1'b1;
            GRP_MASK_CLR: d.clr[IDX_MASK] = 1'b1;
            GRP_SENS_SET: d.set[IDX_SENS] = 1'b1;
            GRP_SENS_CLR: d.clr[IDX_SENS] = 1'b1;
            GRP_SOFT_SET: d.set[IDX_SOFT] = 1'b1;
            GRP_SOFT_CLR: d.clr[IDX_SOFT] = 1'b1;
            GRP_POL_SET:  d.set[IDX_POL]  = 1'b1;
            GRP_POL_CLR:  d.clr[IDX_POL]  = 1'b1;
            default:      d               = '0;
        endcase
        return d;
    endfunction

    function automatic int words_for(int lines);
        return (lines + WORD_BITS - 1) / WORD_BITS;
    endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/xint_w1_reg.sv
module xint_w1_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_i) & ~clr_i;
    end

    assign q_o = q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && !clr_i[i]) |=> q_o[i]);                         // R2
        AST_CLR_STICKS: assert property (@(posedge clk) disable iff (rst)
            clr_i[i] |=> !q_o[i]);                                      // R2
        AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!set_i[i] && !clr_i[i]) |=> (q_o[i] == $past(q_o[i])));    // R2
    end
endmodule

// File: rtl/xint_attr_bank.sv
module xint_attr_bank
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  grp_e                 wr_grp_i,
    input  logic [WIDX_W-1:0]    wr_word_i,
    input  logic [31:0]          wr_data_i,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sens_o,
    output logic [NUM_LINES-1:0] soft_o,
    output logic [NUM_LINES-1:0] pol_o,
    output logic [NUM_LINES-1:0] dom_o,
    output logic [NUM_LINES-1:0] ack_o
);
    wr_dec_t                           dec;
    logic [NUM_LINES-1:0]              line_wd;
    logic [NUM_LINES-1:0]              word_hit;
    logic [N_ATTR-1:0][NUM_LINES-1:0]  set_v;
    logic [N_ATTR-1:0][NUM_LINES-1:0]  clr_v;
    logic [N_ATTR-1:0][NUM_LINES-1:0]  attr_q;
    logic [NUM_LINES-1:0]              dom_q;

    assign dec = decode_write(wr_grp_i);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_spread
        localparam int WI = i / WORD_BITS;
        localparam int BI = i % WORD_BITS;
        assign word_hit[i] = (wr_word_i == WIDX_W'(WI));
        assign line_wd[i]  = word_hit[i] & wr_data_i[BI];

        always_ff @(posedge clk) begin
            if (rst)                               dom_q[i] <= 1'b0;
            else if (wr_en_i && dec.dom && word_hit[i]) dom_q[i] <= wr_data_i[BI];
        end
    end

    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
        assign set_v[a] = (wr_en_i && dec.set[a]) ? line_wd : '0;
        assign clr_v[a] = (wr_en_i && dec.clr[a]) ? line_wd : '0;

        xint_w1_reg #(.W(NUM_LINES)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[a]),
            .clr_i (clr_v[a]),
            .q_o   (attr_q[a])
        );
    end

    assign mask_o = attr_q[IDX_MASK];
    assign sens_o = attr_q[IDX_SENS];
    assign soft_o = attr_q[IDX_SOFT];
    assign pol_o  = attr_q[IDX_POL];
    assign dom_o  = dom_q;
    assign ack_o  = (wr_en_i && dec.ack) ? line_wd : '0;

    AST_ACK_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && dec.ack) |=> ($stable(attr_q) && $stable(dom_q)));  // R5
endmodule

// File: rtl/xint_detect.sv
module xint_detect #(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] sync_i,
    input  logic [NUM_LINES-1:0] sens_i,
    input  logic [NUM_LINES-1:0] pol_i,
    input  logic [NUM_LINES-1:0] soft_i,
    input  logic [NUM_LINES-1:0] dom_i,
    input  logic [NUM_LINES-1:0] ack_i,
    output logic [NUM_LINES-1:0] status_o
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] fall;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] lvl_act;

    always_comb begin
        rise    = sync_i & ~prev_q;
        fall    = ~sync_i & prev_q;
        hit     = ~sens_i & ((pol_i & rise) | (~pol_i & fall));
        lvl_act = sens_i & ~(sync_i ^ pol_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            pend_q <= (pend_q & ~ack_i) | hit;
        end
    end

    assign status_o = dom_i & ((~sens_i & pend_q) | lvl_act | soft_i);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        AST_LATCH_NEEDS_EDGE_TYPE: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_q[i]) |-> !$past(sens_i[i]));                     // R5
        AST_ACK_DROPS_REQUEST: assert property (@(posedge clk) disable iff (rst)
            (ack_i[i] && (sync_i[i] == prev_q[i])) |=> !pend_q[i]);       // R5
        AST_STEADY_INPUT_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
            (!pend_q[i] && (sync_i[i] == prev_q[i])) |=> !pend_q[i]);     // R6
    end
endmodule

// File: rtl/xint_regbank.sv
module xint_regbank
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] ext_line_i,
    input  logic [11:2]          bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [31:0]          bus_wdata_i,
    input  logic                 bus_rd_i,
    output logic [31:0]          bus_rdata_o,
    output logic                 irq_o
);
    localparam int WORDS = words_for(NUM_LINES);
    localparam int PADW  = WORDS * WORD_BITS;

    grp_e                 grp;
    logic [WIDX_W-1:0]    word;
    logic                 in_range;
    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] mask_w, sens_w, soft_w, pol_w, dom_w, ack_w;
    logic [NUM_LINES-1:0] status_w;
    logic [NUM_LINES-1:0] rd_vec;
    logic [PADW-1:0]      rd_pad;
    logic [31:0]          rd_word;
    logic [31:0]          rdata_q;

    assign grp      = grp_e'(bus_addr_i[10:6]);
    assign word     = bus_addr_i[5:2];
    assign in_range = !bus_addr_i[11];

    xint_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_line_i),
        .sync_o  (sync_w)
    );

    xint_attr_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (bus_wr_i && in_range),
        .wr_grp_i  (grp),
        .wr_word_i (word),
        .wr_data_i (bus_wdata_i),
        .mask_o    (mask_w),
        .sens_o    (sens_w),
        .soft_o    (soft_w),
        .pol_o     (pol_w),
        .dom_o     (dom_w),
        .ack_o     (ack_w)
    );

    xint_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_w),
        .sens_i   (sens_w),
        .pol_i    (pol_w),
        .soft_i   (soft_w),
        .dom_i    (dom_w),
        .ack_i    (ack_w),
        .status_o (status_w)
    );

    always_comb begin
        case (grp)
            GRP_STAT: rd_vec = status_w;
            GRP_MASK: rd_vec = mask_w;
            GRP_SENS: rd_vec = sens_w;
            GRP_SOFT: rd_vec = soft_w;
            GRP_POL:  rd_vec = pol_w;
            GRP_DOM:  rd_vec = dom_w;
            default:  rd_vec = '0;
        endcase
        rd_pad                 = '0;
        rd_pad[NUM_LINES-1:0]  = rd_vec;
        rd_word                = '0;
        if (in_range && (int'(word) < WORDS))
            rd_word = rd_pad[int'(word)*WORD_BITS +: WORD_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_word;
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = |(status_w & ~mask_w);

    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|dom_w) |-> !irq_o);                                            // R3
    AST_SOFT_REACHES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (|(soft_w & dom_w & ~mask_w)) |-> irq_o);                         // R7
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && grp == GRP_ACK) |=> (bus_rdata_o == 32'h0));         // R9
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&mask_w) |-> !irq_o);                                            // R8
endmodule

// File: tb/test_xint_regbank.sv
`timescale 1ns/1ps
module test_xint_regbank;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  ext = '0;
    logic [11:2]   addr = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    xint_regbank #(.NUM_LINES(N)) i_xint_regbank (
        .clk         (clk),
        .rst         (rst),
        .ext_line_i  (ext),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  probe = 1'b0;
    logic  probe_d = 1'b0;
    bit    done = 1'b0;

    always @(posedge clk) probe_d <= probe;

    always @(negedge clk) begin
        if (probe_d && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'h0, irq} : rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr32(input int a, input logic [31:0] d);
        @(negedge clk);
        addr  = a[11:2];
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        addr  = a[11:2];
        rd    = 1'b1;
        probe = 1'b1;
        @(negedge clk);
        rd    = 1'b0;
        probe = 1'b0;
        @(negedge clk);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'h0, e}; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(12'h000, 32'h0, "R1 status");
        rd_chk(12'h080, 32'h0, "R1 mask");
        rd_chk(12'h140, 32'h0, "R1 type");
        rd_chk(12'h300, 32'h0, "R1 polarity");
        rd_chk(12'h400, 32'h0, "R1 routing");
        irq_chk(1'b0, "R1 irq");

        // R3 routing enable, R9 unimplemented bits
        wr32(12'h400, 32'hFFFF_FFFF);
        wr32(12'h404, 32'hFFFF_FFFF);
        rd_chk(12'h400, 32'hFFFF_FFFF, "R3 routing word0");
        rd_chk(12'h404, 32'h0000_00FF, "R9 routing word1 upper bits");

        // R2 set/clear aliases, R9 readback not writable
        wr32(12'h0C0, 32'h0000_00F0);
        rd_chk(12'h080, 32'h0000_00F0, "R2 mask set");
        wr32(12'h100, 32'h0000_0030);
        rd_chk(12'h080, 32'h0000_00C0, "R2 mask clear");
        wr32(12'h080, 32'h0000_FFFF);
        rd_chk(12'h080, 32'h0000_00C0, "R9 mask readback write ignored");

        // R4 level operation on line 1
        wr32(12'h180, 32'h2);
        wr32(12'h340, 32'h2);
        rd_chk(12'h140, 32'h2, "R2 type set");
        rd_chk(12'h000, 32'h0, "R4 level high idle");
        ext[1] = 1'b1; settle();
        rd_chk(12'h000, 32'h2, "R4 level high active");
        irq_chk(1'b1, "R8 irq from level");
        ext[1] = 1'b0; settle();
        rd_chk(12'h000, 32'h0, "R4 level high released");
        irq_chk(1'b0, "R8 irq drops");
        wr32(12'h380, 32'h2);
        rd_chk(12'h000, 32'h2, "R4 level low active");
        ext[1] = 1'b1; settle();
        rd_chk(12'h000, 32'h0, "R4 level low released");

        // R5 rising edge on line 35 (word1 bit3)
        wr32(12'h344, 32'h8);
        ext[35] = 1'b1; settle();
        rd_chk(12'h004, 32'h8, "R5 rising latched");
        irq_chk(1'b1, "R8 irq from edge");
        ext[35] = 1'b0; settle();
        rd_chk(12'h004, 32'h8, "R5 latch holds");
        wr32(12'h044, 32'h4);
        rd_chk(12'h004, 32'h8, "R5 ack zero bit keeps");
        wr32(12'h044, 32'h8);
        rd_chk(12'h004, 32'h0, "R5 ack clears");
        irq_chk(1'b0, "R8 irq after ack");

        // R5 falling edge on line 34
        ext[34] = 1'b1; settle();
        rd_chk(12'h004, 32'h0, "R5 rising ignored on falling line");
        ext[34] = 1'b0; settle();
        rd_chk(12'h004, 32'h4, "R5 falling latched");
        wr32(12'h044, 32'h4);
        rd_chk(12'h004, 32'h0, "R5 falling ack");

        // R6 polarity flips with steady inputs
        wr32(12'h384, 32'h8); settle();
        rd_chk(12'h004, 32'h0, "R6 flip low input");
        wr32(12'h344, 32'h8); settle();
        wr32(12'h344, 32'h4); settle();
        rd_chk(12'h004, 32'h0, "R6 flip back");
        ext[35] = 1'b1; settle();
        wr32(12'h044, 32'h8);
        wr32(12'h384, 32'h8); settle();
        rd_chk(12'h004, 32'h0, "R6 flip high input");

        // R7 soft request on line 5
        wr32(12'h240, 32'h20);
        rd_chk(12'h200, 32'h20, "R2 soft set");
        rd_chk(12'h000, 32'h20, "R7 soft status");
        irq_chk(1'b1, "R7 soft irq");
        wr32(12'h280, 32'h20);
        rd_chk(12'h200, 32'h0, "R2 soft clear");
        irq_chk(1'b0, "R7 soft withdrawn");

        // R8 masking
        wr32(12'h240, 32'h40);
        rd_chk(12'h000, 32'h40, "R8 masked line status");
        irq_chk(1'b0, "R8 masked no irq");
        wr32(12'h100, 32'h40);
        irq_chk(1'b1, "R8 unmasked irq");
        wr32(12'h0C0, 32'h40);
        irq_chk(1'b0, "R8 remasked");
        wr32(12'h280, 32'h40);

        // R3 routing gate
        wr32(12'h400, 32'h0);
        wr32(12'h240, 32'h20);
        rd_chk(12'h000, 32'h0, "R3 unrouted status");
        irq_chk(1'b0, "R3 unrouted irq");
        wr32(12'h400, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h20, "R3 rerouted status");
        irq_chk(1'b1, "R3 rerouted irq");
        wr32(12'h280, 32'h20);

        // R9 read-only and empty locations
        rd_chk(12'h014, 32'h0, "R9 status word beyond range");
        wr32(12'h000, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h0, "R9 status write ignored");
        rd_chk(12'h040, 32'h0, "R9 ack reads zero");
        rd_chk(12'h0C0, 32'h0, "R9 alias reads zero");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule